// File: doc/BRIEF.md
# Augmented CRC-16 Byte Engine

This block computes a 16-bit cyclic redundancy check over a byte stream. It uses the augmented form: the message is shifted through the register and the divisor is subtracted. Bytes arrive one per clock over a valid/ready handshake. The register shifts left one bit at a time. Each data bit enters at the bottom, and the generator constant is XORed in whenever a one leaves the top. Because of this ordering, two zero bytes must be pushed through after the message before the register holds the check value. A finish command performs those two zero-byte steps internally. During that time it holds off new input, and it then raises a one-cycle done pulse.

A sender clears the engine, streams the message, issues finish, and then transmits the high output byte followed by the low one. A receiver clears the engine and streams the message followed by both check bytes, without issuing finish. A registered zero flag then reports whether the block arrived intact. The generator constant is chosen between two values by a select input, which is captured only at clear.

Top module: `crc16_aug_engine`

## Requirements
- R1: After reset and after a clear with no byte offered, the register reads 0x0000 on both output bytes and the zero flag is 1.
- R2: With select 0 captured, each accepted byte is consumed most significant bit first over eight steps. Each step shifts the register left by one and places the data bit at bit 0. If the bit that left bit 15 was 1, the register is then XORed with 0x1021.
- R3: With select 1 captured, the same step uses the constant 0x8005 instead.
- R4: A byte is accepted on every clock edge where valid and ready are both high, so back-to-back bytes are taken on consecutive cycles. With nothing accepted and no flush running, the register holds its value.
- R5: When finish is seen while ready is high, ready is low for the next two cycles. During those cycles the register takes two zero-byte steps. The done output is 1 for exactly the one cycle in which the final value first appears. Bytes offered while ready is low are ignored. A byte accepted in the same cycle as finish is included before the flush.
- R6: The high output byte carries register bits 15:8 and the low output byte carries bits 7:0. The high byte is the one sent first.
- R7: Streaming a message followed by its high and then its low check byte, after a clear, leaves the register at 0x0000 and the zero flag at 1.
- R8: If clear and a valid byte arrive in the same cycle, clear wins. The byte is then processed as the first byte of the new block, starting from 0x0000 and using the newly captured select.
- R9: The zero flag is registered. It shows whether the register was 0x0000 after the most recent clear or accepted byte, and the finish flush leaves it unchanged.
- R10: The polynomial select is sampled only in a clear cycle. Changing it during a block has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new block: register to zero, capture select |
| poly_sel_i | input | 1 | 0 selects 0x1021, 1 selects 0x8005 |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Byte value |
| in_ready_o | output | 1 | Engine can accept a byte |
| finish_i | input | 1 | Run the two zero-byte flush |
| done_o | output | 1 | One-cycle pulse when the check value is ready |
| crc_hi_o | output | 8 | Register bits 15:8 |
| crc_lo_o | output | 8 | Register bits 7:0 |
| zero_o | output | 1 | Register was zero after the last clear or accepted byte |

## Verification
Every byte value is swept through a single-byte block under both constants. Each block opens with clear and the byte in the same cycle, so a design that applied the byte before clearing, or with the old constant, would get the wrong value. Junk bytes are offered throughout every flush. A design that took them, or that let the flush change the zero flag, would produce a wrong check value or a wrong flag. The sweep also checks that done lasts a single cycle and that ready is low for exactly two cycles. Known nine-byte vectors are streamed back to back, with the select toggled in the middle of the block. This exposes any bubble in the handshake, a swapped byte order, or a constant switched partway through. Feeding each check value back in must bring the register to zero.

// File: rtl/crc16_aug_engine.sv
module crc16_aug_engine #(
  parameter logic [15:0] POLY_A = 16'h1021,
  parameter logic [15:0] POLY_B = 16'h8005,
  parameter int          FLUSH_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       poly_sel_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  input  logic       finish_i,
  output logic       done_o,
  output logic [7:0] crc_hi_o,
  output logic [7:0] crc_lo_o,
  output logic       zero_o
);
  localparam int CW = $clog2(FLUSH_BYTES + 1);

  function automatic logic [15:0] byte_step(input logic [15:0] c, input logic [7:0] d,
                                            input logic [15:0] p);
    logic [15:0] r;
    logic        out_bit;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      out_bit = r[15];
      r = {r[14:0], d[i]};
      if (out_bit) r = r ^ p;
    end
    return r;
  endfunction

  logic [15:0] crc_q;
  logic        poly_q, zero_q, done_q;
  logic [CW-1:0] flush_q;

  logic        accept;
  logic [15:0] poly_use, base, byte_next, flush_next;

  assign in_ready_o = (flush_q == '0);
  assign accept     = in_valid_i && in_ready_o;
  assign poly_use   = (clear_i ? poly_sel_i : poly_q) ? POLY_B : POLY_A;
  assign base       = clear_i ? 16'h0000 : crc_q;
  assign byte_next  = byte_step(base, in_data_i, poly_use);
  assign flush_next = byte_step(crc_q, 8'h00, poly_q ? POLY_B : POLY_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= '0;
      poly_q  <= 1'b0;
      zero_q  <= 1'b1;
      done_q  <= 1'b0;
      flush_q <= '0;
    end else if (clear_i) begin
      poly_q  <= poly_sel_i;
      done_q  <= 1'b0;
      flush_q <= '0;
      if (accept) begin
        crc_q  <= byte_next;
        zero_q <= (byte_next == 16'h0000);
      end else begin
        crc_q  <= '0;
        zero_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
      if (flush_q != '0) begin
        crc_q   <= flush_next;
        flush_q <= flush_q - 1'b1;
        if (flush_q == CW'(1)) done_q <= 1'b1;
      end else begin
        if (accept) begin
          crc_q  <= byte_next;
          zero_q <= (byte_next == 16'h0000);
        end
        if (finish_i) flush_q <= CW'(FLUSH_BYTES);
      end
    end
  end

  assign crc_hi_o = crc_q[15:8];
  assign crc_lo_o = crc_q[7:0];
  assign zero_o   = zero_q;
  assign done_o   = done_q;
endmodule

module crc16_aug_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clear_i,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       finish_i,
  input logic       done_o,
  input logic [7:0] crc_hi_o,
  input logic [7:0] crc_lo_o,
  input logic       zero_o
);
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && !in_valid_i |=> ({crc_hi_o, crc_lo_o} == 16'h0000) && zero_o);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o && !in_valid_i && !finish_i && !clear_i |=> $stable({crc_hi_o, crc_lo_o}));

  assert_flush_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i && in_ready_o && !clear_i |=> !in_ready_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> in_ready_o && !$past(in_ready_o));

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i || (in_valid_i && in_ready_o) |=> zero_o == ({crc_hi_o, crc_lo_o} == 16'h0000));

  assert_flush_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready_o && !clear_i |=> $stable(zero_o));
endmodule

bind crc16_aug_engine crc16_aug_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .finish_i(finish_i), .done_o(done_o),
  .crc_hi_o(crc_hi_o), .crc_lo_o(crc_lo_o), .zero_o(zero_o)
);

// File: tb/crc16_aug_engine_test.sv
`timescale 1ns/1ps
module crc16_aug_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clear_i = 0, poly_sel_i = 0, in_valid_i = 0, finish_i = 0;
  logic [7:0] in_data_i = 0;
  logic in_ready_o, done_o, zero_o;
  logic [7:0] crc_hi_o, crc_lo_o;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc16_aug_engine uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .poly_sel_i(poly_sel_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .finish_i(finish_i), .done_o(done_o), .crc_hi_o(crc_hi_o),
    .crc_lo_o(crc_lo_o), .zero_o(zero_o)
  );

  // Long-division reference: 17-bit remainder window
  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d, input bit sel);
    logic [16:0] w;
    logic [16:0] g;
    g = sel ? 17'h18005 : 17'h11021;
    w = {1'b0, c};
    for (int k = 0; k < 8; k++) begin
      w = {w[15:0], d[7-k]};
      if (w[16]) w = w ^ g;
    end
    return w[15:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clear(input bit sel);
    @(negedge clk); clear_i = 1; poly_sel_i = sel;
    @(negedge clk); clear_i = 0;
  endtask

  task automatic send_stream(input logic [7:0] b[], input bit toggle_sel);
    foreach (b[i]) begin
      @(negedge clk); in_valid_i = 1; in_data_i = b[i];
      if (toggle_sel) poly_sel_i = ~poly_sel_i;
    end
    @(negedge clk); in_valid_i = 0;
  endtask

  // Finish with junk offered during stall; returns at the done cycle
  task automatic do_finish(input logic [7:0] junk);
    @(negedge clk); finish_i = 1;
    @(negedge clk); finish_i = 0; in_valid_i = 1; in_data_i = junk;
    chk("R5 ready low 1", in_ready_o, 0);
    @(negedge clk);
    chk("R5 ready low 2", in_ready_o, 0);
    chk("R5 no early done", done_o, 0);
    @(negedge clk); in_valid_i = 0;
    chk("R5 done", done_o, 1);
    chk("R5 ready back", in_ready_o, 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] msg[] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    logic [15:0] after_b, tx;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    chk("R1 reset crc", {crc_hi_o, crc_lo_o}, 0);
    chk("R1 reset zero", zero_o, 1);
    rst_n = 1;

    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 256; b++) begin
        // R8: clear and byte together
        @(negedge clk); clear_i = 1; poly_sel_i = p[0]; in_valid_i = 1; in_data_i = b[7:0];
        @(negedge clk); clear_i = 0; in_valid_i = 0;
        after_b = ref_byte(16'h0, b[7:0], p[0]);
        chk("R8 clear+byte", {crc_hi_o, crc_lo_o}, after_b);
        tx = ref_byte(ref_byte(after_b, 8'h00, p[0]), 8'h00, p[0]);
        do_finish(~b[7:0]);
        chk(p ? "R3 check value" : "R2 check value", {crc_hi_o, crc_lo_o}, tx);
        chk("R9 flag kept", zero_o, after_b == 0);
        @(negedge clk);
        chk("R5 done one cycle", done_o, 0);
        chk("R4 idle hold", {crc_hi_o, crc_lo_o}, tx);
        do_clear(p[0]);
        chk("R1 clear crc", {crc_hi_o, crc_lo_o}, 0);
        chk("R1 clear zero", zero_o, 1);
        send_stream('{b[7:0], tx[15:8], tx[7:0]}, 0);
        chk("R7 receive zero", zero_o, 1);
      end
    end

    // Known vectors, back-to-back, select toggled mid-block
    for (int p = 0; p < 2; p++) begin
      do_clear(p[0]);
      send_stream(msg, 1);
      e = 0;
      foreach (msg[i]) e = ref_byte(e, msg[i], p[0]);
      chk("R4 back-to-back", {crc_hi_o, crc_lo_o}, e);
      do_finish(8'hA5);
      chk("R10 select ignored", {crc_hi_o, crc_lo_o}, p ? 16'hFEE8 : 16'h31C3);
      chk("R6 high byte", crc_hi_o, p ? 8'hFE : 8'h31);
      chk("R6 low byte", crc_lo_o, p ? 8'hE8 : 8'hC3);
      poly_sel_i = p[0];
      do_clear(p[0]);
      send_stream('{msg[0], msg[1], msg[2], msg[3], msg[4], msg[5], msg[6], msg[7], msg[8],
                    (p ? 8'hFE : 8'h31), (p ? 8'hE8 : 8'hC3)}, 0);
      chk("R7 vector receive", {crc_hi_o, crc_lo_o}, 0);
      chk("R9 zero after bytes", zero_o, 1);
    end

    // 'A' under 0x1021; finish in same cycle as the byte
    do_clear(0);
    @(negedge clk); in_valid_i = 1; in_data_i = 8'h41; finish_i = 1;
    @(negedge clk); in_valid_i = 0; finish_i = 0;
    chk("R5 byte with finish stalls", in_ready_o, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 done byte+finish", done_o, 1);
    chk("R2 letter A", {crc_hi_o, crc_lo_o}, 16'h58E5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule